// File: doc/BRIEF.md
# Flag Offset Register Load Controller

This block holds the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against: an empty-side offset and a full-side offset, each 12 bits by default. Both registers are reached through the FIFO's normal data input and write request. They are read back through the normal data output and read request. A separate active-low program select turns those requests into offset accesses.

A single sequence pointer decides which register the next access touches. It starts at the empty offset and toggles after every load or readback. If a programming session stops partway, the pointer keeps its position, so the next session resumes with the other register. While program select is active, the qualified memory enables the block hands to the FIFO core stay low. Offset traffic therefore never moves FIFO data or pointers. Reset restores a default offset that depends on the FIFO depth.

The design uses one clock for both the write side and the read side. It is intended for a synchronous FIFO.

Top module: `ofs_load_ctl`

## Requirements
- R1: After reset, the empty and full offsets equal the depth default, `rd_data` is 0, `rd_vld` is 0, and the pointer selects the empty offset.
- R2: The depth default is 31 for DEPTH 256, 63 for DEPTH 512, and 127 for any other depth.
- R3: On a rising clock with `prog_sel_n`=0 and `wr_req_n`=0, `din` is written into the offset register the pointer selects. The new value is visible on `empty_ofs` or `full_ofs` after that edge.
- R4: Successive loads alternate between the two registers: empty, full, empty, full, and so on.
- R5: Raising `prog_sel_n` between loads leaves the pointer where it was. The next load writes the register after the last one written.
- R6: With `prog_sel_n`=1, a write request changes neither offset and raises `mem_wr_en` in the same cycle.
- R7: On a rising clock with `prog_sel_n`=0 and `rd_req_n`=0, the selected offset is registered onto `rd_data[11:0]` with the upper bits 0, and `rd_vld` is 1 for the following cycle.
- R8: Every readback advances the same pointer that loads use, so loads and readbacks interleave in one alternating sequence.
- R9: While `prog_sel_n`=0, `mem_wr_en` and `mem_rd_en` are both 0.
- R10: A load and a readback on the same edge return the selected register's value from before the write, write the new value, and advance the pointer by one position.
- R11: In a cycle without a readback, `rd_data` holds its value and `rd_vld` is 0. In a cycle without a load, both offsets hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_sel_n | input | 1 | Active-low select that redirects requests to the offset registers |
| wr_req_n | input | 1 | Active-low write request |
| rd_req_n | input | 1 | Active-low read request |
| din | input | OFS_W (12) | Offset field of the shared data input |
| mem_wr_en | output | 1 | Qualified write enable for the FIFO memory |
| mem_rd_en | output | 1 | Qualified read enable for the FIFO memory |
| empty_ofs | output | OFS_W (12) | Empty-side offset to the flag logic |
| full_ofs | output | OFS_W (12) | Full-side offset to the flag logic |
| rd_data | output | DATA_W (18) | Registered offset readback, zero-extended |
| rd_vld | output | 1 | High for the cycle in which `rd_data` carries a fresh readback |

## Verification
The memory enables are combinational, so the bench samples them 1 ns after it drives the inputs on the falling edge. This happens before the rising edge that would consume them. Offsets, `rd_data` and `rd_vld` each pass through exactly one register, so the bench samples them 1 ns after the rising edge that performs the access. It updates its arithmetic model of the two offsets and the pointer at that same edge. Directed sequences cover partial sessions, mixed load and readback, same-edge collisions, and the defaults of three depth instances. A long sweep then applies every combination of the three requests with varying data and compares all outputs every cycle.

// File: rtl/ofs_ctl_pkg.sv
package ofs_ctl_pkg;

   typedef enum logic {
      SEL_EMPTY = 1'b0,
      SEL_FULL  = 1'b1
   } ofs_sel_e;

   function automatic int unsigned depth_default(input int unsigned depth);
      if (depth == 256) return 31;
      else if (depth == 512) return 63;
      else return 127;
   endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr
   import ofs_ctl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   output ofs_sel_e sel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel <= SEL_EMPTY;
      else if (adv)
         sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
   end

   // R8: each access moves the pointer to the other register
   assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> sel != $past(sel));
   // R5: with no access the pointer keeps its place
   assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(sel));

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
   import ofs_ctl_pkg::*;
#(
   parameter int unsigned OFS_W = 12,
   parameter logic [OFS_W-1:0] DEF_OFS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  ofs_sel_e         sel,
   input  logic [OFS_W-1:0] din_ofs,
   output logic [OFS_W-1:0] empty_q,
   output logic [OFS_W-1:0] full_q
);

   localparam int unsigned N_REG = 2;

   logic [OFS_W-1:0] bank [N_REG];

   for (genvar g = 0; g < N_REG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank[g] <= DEF_OFS;
         else if (load && (int'(sel) == g))
            bank[g] <= din_ofs;
      end
   end

   assign empty_q = bank[int'(SEL_EMPTY)];
   assign full_q  = bank[int'(SEL_FULL)];

   // R3: a load lands in the register the pointer named
   assert_load_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sel == SEL_EMPTY) |=> empty_q == $past(din_ofs));
   assert_load_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sel == SEL_FULL) |=> full_q == $past(din_ofs));
   // R11: without a load both offsets hold
   assert_ofs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(empty_q) && $stable(full_q)));

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
   import ofs_ctl_pkg::*;
#(
   parameter int unsigned OFS_W  = 12,
   parameter int unsigned DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  ofs_sel_e          sel,
   input  logic [OFS_W-1:0]  empty_q,
   input  logic [OFS_W-1:0]  full_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld
);

   logic [OFS_W-1:0]  pick;
   logic [DATA_W-1:0] wide;

   assign pick = (sel == SEL_FULL) ? full_q : empty_q;

   if (DATA_W > OFS_W) begin : g_pad
      assign wide = {{(DATA_W - OFS_W){1'b0}}, pick};
   end else begin : g_flat
      assign wide = pick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= fire;
         if (fire)
            rd_data <= wide;
      end
   end

   // R7: readback data is the register selected at the access edge
   assert_rdbk_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (rd_vld && rd_data[OFS_W-1:0] == $past(pick)));
   // R11: no readback, no valid, data held
   assert_rdbk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> (!rd_vld && $stable(rd_data)));

endmodule

// File: rtl/ofs_load_ctl.sv
module ofs_load_ctl
   import ofs_ctl_pkg::*;
#(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned OFS_W  = 12,
   parameter int unsigned DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_sel_n,
   input  logic              wr_req_n,
   input  logic              rd_req_n,
   input  logic [OFS_W-1:0]  din,
   output logic              mem_wr_en,
   output logic              mem_rd_en,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld
);

   localparam int unsigned DEF_INT = depth_default(DEPTH);
   localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(DEF_INT);

   if (OFS_W < 7 || OFS_W > 32) begin : g_bad_ofs_w
      $error("OFS_W must lie in 7..32");
   end
   if (DATA_W < OFS_W) begin : g_bad_data_w
      $error("DATA_W must be at least OFS_W");
   end
   if (DEPTH < 2 * (DEF_INT + 1)) begin : g_bad_depth
      $error("DEPTH too small for its default offset");
   end

   logic     load_fire;
   logic     rdbk_fire;
   ofs_sel_e sel;

   assign load_fire = !prog_sel_n && !wr_req_n;
   assign rdbk_fire = !prog_sel_n && !rd_req_n;
   assign mem_wr_en = prog_sel_n && !wr_req_n;
   assign mem_rd_en = prog_sel_n && !rd_req_n;

   ofs_seq_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (load_fire || rdbk_fire),
      .sel   (sel)
   );

   ofs_reg_bank #(
      .OFS_W   (OFS_W),
      .DEF_OFS (DEF_OFS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_fire),
      .sel     (sel),
      .din_ofs (din),
      .empty_q (empty_ofs),
      .full_q  (full_ofs)
   );

   ofs_readback #(
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W)
   ) u_rdbk (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (rdbk_fire),
      .sel     (sel),
      .empty_q (empty_ofs),
      .full_q  (full_ofs),
      .rd_data (rd_data),
      .rd_vld  (rd_vld)
   );

   // R9: offset traffic never reaches the FIFO memory
   assert_mem_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fire || rdbk_fire) |-> !(mem_wr_en || mem_rd_en));
   // R10: a same-edge load leaves the readback with the pre-write value
   assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fire && rdbk_fire && sel == SEL_EMPTY) |=>
         rd_data[OFS_W-1:0] == $past(empty_ofs));

endmodule

// File: tb/ofs_load_ctl_bench.sv
`timescale 1ns/1ps
module ofs_load_ctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_sel_n = 1'b1;
   logic        wr_req_n = 1'b1;
   logic        rd_req_n = 1'b1;
   logic [11:0] din = '0;
   logic        mem_wr_en, mem_rd_en, rd_vld;
   logic [11:0] empty_ofs, full_ofs;
   logic [17:0] rd_data;
   logic        w5_mwr, w5_mrd, w5_vld, w1_mwr, w1_mrd, w1_vld;
   logic [11:0] w5_e, w5_f, w1_e, w1_f;
   logic [17:0] w5_d, w1_d;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // model state
   logic [11:0] m_e, m_f;
   logic [17:0] m_d;
   logic        m_v;
   logic        m_ptr;

   always #10 clk = ~clk;

   ofs_load_ctl u_ofs_load_ctl (
      .clk(clk), .rst_n(rst_n), .prog_sel_n(prog_sel_n), .wr_req_n(wr_req_n),
      .rd_req_n(rd_req_n), .din(din), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
      .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data), .rd_vld(rd_vld)
   );

   ofs_load_ctl #(.DEPTH(512)) u_d512 (
      .clk(clk), .rst_n(rst_n), .prog_sel_n(prog_sel_n), .wr_req_n(wr_req_n),
      .rd_req_n(rd_req_n), .din(din), .mem_wr_en(w5_mwr), .mem_rd_en(w5_mrd),
      .empty_ofs(w5_e), .full_ofs(w5_f), .rd_data(w5_d), .rd_vld(w5_vld)
   );

   ofs_load_ctl #(.DEPTH(1024)) u_d1024 (
      .clk(clk), .rst_n(rst_n), .prog_sel_n(prog_sel_n), .wr_req_n(wr_req_n),
      .rd_req_n(rd_req_n), .din(din), .mem_wr_en(w1_mwr), .mem_rd_en(w1_mrd),
      .empty_ofs(w1_e), .full_ofs(w1_f), .rd_data(w1_d), .rd_vld(w1_vld)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic model_reset();
      m_e = 12'd31; m_f = 12'd31; m_d = '0; m_v = 1'b0; m_ptr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; prog_sel_n = 1'b1; wr_req_n = 1'b1; rd_req_n = 1'b1; din = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic step(input logic p, input logic w, input logic r, input logic [11:0] d);
      logic lf, rf;
      @(negedge clk);
      prog_sel_n = p; wr_req_n = w; rd_req_n = r; din = d;
      #1;
      chk(p ? "R6 mem_wr_en" : "R9 mem_wr_en", {31'b0, mem_wr_en}, {31'b0, p & ~w});
      chk("R9 mem_rd_en", {31'b0, mem_rd_en}, {31'b0, p & ~r});
      @(posedge clk);
      #1;
      lf = !p && !w;
      rf = !p && !r;
      m_v = rf;
      if (rf) m_d = {6'b0, (m_ptr ? m_f : m_e)};
      if (lf) begin
         if (m_ptr) m_f = d; else m_e = d;
      end
      if (lf || rf) m_ptr = ~m_ptr;
      chk("R3 empty_ofs", {20'b0, empty_ofs}, {20'b0, m_e});
      chk("R3 full_ofs", {20'b0, full_ofs}, {20'b0, m_f});
      chk("R7 rd_data", {14'b0, rd_data}, {14'b0, m_d});
      chk("R11 rd_vld", {31'b0, rd_vld}, {31'b0, m_v});
   endtask

   initial begin
      #(20 * 200000);
      chk("watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      do_reset();
      #1;
      // R1 / R2: reset state and depth defaults
      chk("R1 empty default", {20'b0, empty_ofs}, 32'd31);
      chk("R1 full default", {20'b0, full_ofs}, 32'd31);
      chk("R1 rd_data", {14'b0, rd_data}, 32'd0);
      chk("R1 rd_vld", {31'b0, rd_vld}, 32'd0);
      chk("R2 depth512 empty", {20'b0, w5_e}, 32'd63);
      chk("R2 depth512 full", {20'b0, w5_f}, 32'd63);
      chk("R2 depth1024 empty", {20'b0, w1_e}, 32'd127);
      chk("R2 depth1024 full", {20'b0, w1_f}, 32'd127);

      // R4: alternation empty, full, empty
      step(1'b0, 1'b0, 1'b1, 12'h123);
      chk("R4 first load to empty", {20'b0, empty_ofs}, 32'h123);
      step(1'b0, 1'b0, 1'b1, 12'h456);
      chk("R4 second load to full", {20'b0, full_ofs}, 32'h456);
      step(1'b0, 1'b0, 1'b1, 12'h789);
      chk("R4 third load to empty", {20'b0, empty_ofs}, 32'h789);

      // R5: session break keeps the pointer at full
      step(1'b1, 1'b1, 1'b1, 12'h000);
      step(1'b1, 1'b1, 1'b1, 12'hFFF);
      step(1'b0, 1'b0, 1'b1, 12'hABC);
      chk("R5 resumed load to full", {20'b0, full_ofs}, 32'hABC);
      chk("R5 empty kept", {20'b0, empty_ofs}, 32'h789);

      // R6: write with select released is ignored by the offsets
      step(1'b1, 1'b0, 1'b1, 12'h555);
      chk("R6 empty unchanged", {20'b0, empty_ofs}, 32'h789);
      chk("R6 full unchanged", {20'b0, full_ofs}, 32'hABC);

      // R7 / R8: readback walks the same sequence
      step(1'b0, 1'b1, 1'b0, 12'h000);
      chk("R7 readback empty", {14'b0, rd_data}, 32'h789);
      chk("R7 readback valid", {31'b0, rd_vld}, 32'd1);
      step(1'b0, 1'b1, 1'b0, 12'h000);
      chk("R8 readback full", {14'b0, rd_data}, 32'hABC);
      step(1'b1, 1'b1, 1'b1, 12'h000);
      chk("R11 data held", {14'b0, rd_data}, 32'hABC);
      chk("R11 valid low", {31'b0, rd_vld}, 32'd0);
      step(1'b0, 1'b1, 1'b0, 12'h000);
      step(1'b0, 1'b0, 1'b1, 12'h111);
      chk("R8 load after readback to full", {20'b0, full_ofs}, 32'h111);
      chk("R8 empty untouched", {20'b0, empty_ofs}, 32'h789);

      // R10: same-edge load and readback
      step(1'b0, 1'b0, 1'b0, 12'h222);
      chk("R10 readback pre-write", {14'b0, rd_data}, 32'h789);
      chk("R10 write landed", {20'b0, empty_ofs}, 32'h222);
      step(1'b0, 1'b0, 1'b1, 12'h333);
      chk("R10 single advance", {20'b0, full_ofs}, 32'h333);

      // R1: reset mid-use restores defaults and pointer
      step(1'b0, 1'b0, 1'b1, 12'h444);
      do_reset();
      #1;
      chk("R1 empty after reset", {20'b0, empty_ofs}, 32'd31);
      chk("R1 full after reset", {20'b0, full_ofs}, 32'd31);
      step(1'b0, 1'b0, 1'b1, 12'h0AA);
      chk("R1 pointer at empty", {20'b0, empty_ofs}, 32'h0AA);
      chk("R1 full still default", {20'b0, full_ofs}, 32'd31);

      // sweep of every request combination with varying data
      for (int i = 0; i < 600; i++) begin
         int pat;
         pat = (i * 13 + (i >> 3)) % 8;
         step(pat[2], pat[1], pat[0], 12'((i * 1237 + 433) ^ (i << 5)));
      end

      finish_run();
   end

endmodule